// File: doc/BRIEF.md
# Split Request Packet Issuer

This block sends the packets of one memory access that straddles a cache-line boundary. The access is broken into one to four packets, which must reach a cache port strictly in index order. The port uses a valid/ready handshake, takes at most one packet per cycle and may refuse a packet. The issuer keeps two counters. One counts packets sent and still awaiting a response. The other counts packets whose response has come back. The index offered to the port is always the sum of the two counters.

A start pulse loads the packet count and clears both counters. From then on the issuer offers the next unsent index every cycle. A refusal stops the attempt, and the same index is offered again on the next cycle. If a refusal comes with a bank-conflict indication, the issuer spends one cycle in a replay slot: it pulses a replay flag and offers nothing. Issuing resumes on the cycle after that. A response moves one packet from outstanding to received. An all-sent flag shows when every packet of the request is outstanding at once.

Top module: `split_pkt_issuer`

## Requirements
- R1: During and after reset, with no start pulse, pkt_valid_o, replay_o and all_sent_o are low, and both counters read zero.
- R2: A start pulse loads the packet count from num_pkts_i, clamped to the range 1 to 4 (0 becomes 1, 5 to 7 become 4). It clears both counters. A start pulse takes priority over any issue or response in the same cycle.
- R3: While a request is active and not in a replay slot, pkt_valid_o is high exactly when received plus outstanding is below the packet count. pkt_idx_o then equals received plus outstanding.
- R4: A cycle with pkt_valid_o and pkt_ready_i both high raises the outstanding count by one at the next edge.
- R5: A refused cycle (pkt_valid_o high, pkt_ready_i low, bank_conflict_i low) leaves the counters unchanged. The same index is offered again on the next cycle, so no packet is skipped or reordered.
- R6: A refused cycle with bank_conflict_i high makes replay_o high for exactly the next cycle. pkt_valid_o is low in that cycle, and issuing resumes on the cycle after it.
- R7: bank_conflict_i has no effect in a cycle where no packet is refused. No replay slot follows.
- R8: resp_i with a nonzero outstanding count lowers outstanding by one and raises received by one. If a packet is accepted in the same cycle, both updates apply, so outstanding stays the same and received rises by one.
- R9: resp_i while the outstanding count is zero is ignored. Both counters stay unchanged.
- R10: all_sent_o is high exactly when a request is active and the outstanding count equals the packet count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new request |
| num_pkts_i | input | 3 | Packet count for the request (clamped to 1..4) |
| pkt_ready_i | input | 1 | Cache port accepts the offered packet |
| bank_conflict_i | input | 1 | Refusal was caused by a bank conflict |
| resp_i | input | 1 | One response returned |
| pkt_valid_o | output | 1 | A packet is offered |
| pkt_idx_o | output | 2 | Index of the offered packet |
| replay_o | output | 1 | Replay slot in progress |
| all_sent_o | output | 1 | Every packet is outstanding |
| outs_cnt_o | output | 3 | Outstanding packet count |
| recv_cnt_o | output | 3 | Received packet count |

## Verification
Directed sequences separate an accepted send from a plain refusal and from a conflict refusal. The three must give a counter step, an unchanged index, and a one-cycle replay slot respectively. Responses are driven alone, together with an accept, and with nothing outstanding. This shows that both updates combine and that the empty case is ignored. The packet count is tried at 0 and 7 for the clamp, and a restart is tried in the middle of a request. Every count from 1 to 4 is then swept under pseudo-random ready, conflict and response patterns. A cycle model in the bench predicts the index, the flags and both counters on every cycle.

// File: rtl/split_iss_pkg.sv
package split_iss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_REPLAY = 2'd2
  } iss_st_e;
endpackage

// File: rtl/split_iss_cnt.sv
module split_iss_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             acc_i,
  input  logic             resp_i,
  output logic [CNT_W-1:0] outs_o,
  output logic [CNT_W-1:0] recv_o
);
  logic [CNT_W-1:0] outs_q, recv_q;
  logic             rsp_ok;

  // a response with nothing in flight is dropped
  assign rsp_ok = resp_i && (outs_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outs_q <= '0;
      recv_q <= '0;
    end else if (clr_i) begin
      outs_q <= '0;
      recv_q <= '0;
    end else begin
      outs_q <= outs_q + CNT_W'(acc_i) - CNT_W'(rsp_ok);
      recv_q <= recv_q + CNT_W'(rsp_ok);
    end
  end

  assign outs_o = outs_q;
  assign recv_o = recv_q;

  a_r9_resp_empty_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_i && outs_q == '0 && !clr_i) |=> (recv_q == $past(recv_q)));
  a_r8_resp_and_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_i && acc_i && outs_q != '0 && !clr_i) |=> (outs_q == $past(outs_q) && recv_q == $past(recv_q) + 1'b1));
endmodule

// File: rtl/split_iss_ctrl.sv
module split_iss_ctrl
  import split_iss_pkg::*;
#(
  parameter int MAX_PKTS = 4,
  parameter int CNT_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] num_i,
  input  logic [CNT_W-1:0] sum_i,
  input  logic             ready_i,
  input  logic             conflict_i,
  output logic             valid_o,
  output logic             replay_o,
  output logic             active_o,
  output logic [CNT_W-1:0] total_o
);
  iss_st_e          state_q, state_d;
  logic [CNT_W-1:0] total_q, num_clamped;
  logic             refuse;

  always_comb begin
    if (num_i == '0)                    num_clamped = CNT_W'(1);
    else if (num_i > CNT_W'(MAX_PKTS))  num_clamped = CNT_W'(MAX_PKTS);
    else                                num_clamped = num_i;
  end

  assign valid_o  = (state_q == ST_ISSUE) && (sum_i < total_q);
  assign refuse   = valid_o && !ready_i;
  assign replay_o = (state_q == ST_REPLAY);
  assign active_o = (state_q != ST_IDLE);
  assign total_o  = total_q;

  always_comb begin
    state_d = state_q;
    if (start_i)                       state_d = ST_ISSUE;
    else if (state_q == ST_REPLAY)     state_d = ST_ISSUE;
    else if (refuse && conflict_i)     state_d = ST_REPLAY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      total_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_i) total_q <= num_clamped;
    end
  end

  a_r6_conflict_replay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refuse && conflict_i && !start_i) |=> (replay_o && !valid_o));
  a_r6_replay_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (replay_o && !start_i) |=> !replay_o);
  a_r2_total_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (total_q >= CNT_W'(1) && total_q <= CNT_W'(MAX_PKTS)));
endmodule

// File: rtl/split_pkt_issuer.sv
module split_pkt_issuer #(
  parameter int MAX_PKTS = 4,
  localparam int CNT_W   = $clog2(MAX_PKTS + 1),
  localparam int IDX_W   = $clog2(MAX_PKTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] num_pkts_i,
  input  logic             pkt_ready_i,
  input  logic             bank_conflict_i,
  input  logic             resp_i,
  output logic             pkt_valid_o,
  output logic [IDX_W-1:0] pkt_idx_o,
  output logic             replay_o,
  output logic             all_sent_o,
  output logic [CNT_W-1:0] outs_cnt_o,
  output logic [CNT_W-1:0] recv_cnt_o
);
  logic [CNT_W-1:0] outs, recv, sum, total;
  logic             valid, active, acc;

  assign sum = outs + recv;
  assign acc = valid && pkt_ready_i;

  split_iss_ctrl #(.MAX_PKTS(MAX_PKTS), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .num_i      (num_pkts_i),
    .sum_i      (sum),
    .ready_i    (pkt_ready_i),
    .conflict_i (bank_conflict_i),
    .valid_o    (valid),
    .replay_o   (replay_o),
    .active_o   (active),
    .total_o    (total)
  );

  split_iss_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .acc_i  (acc),
    .resp_i (resp_i),
    .outs_o (outs),
    .recv_o (recv)
  );

  assign pkt_valid_o = valid;
  assign pkt_idx_o   = valid ? sum[IDX_W-1:0] : '0;
  assign all_sent_o  = active && (outs == total);
  assign outs_cnt_o  = outs;
  assign recv_cnt_o  = recv;

  a_r3_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> (CNT_W'(pkt_idx_o) < total));
  a_r3_sum_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> (sum <= total));
  a_r5_refuse_holds_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i && !bank_conflict_i && !start_i) |=>
      (pkt_valid_o && pkt_idx_o == $past(pkt_idx_o)));
  a_r4_accept_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_ready_i && !resp_i && !start_i) |=> (outs_cnt_o == $past(outs_cnt_o) + 1'b1));
  a_r10_all_sent_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_sent_o |-> !pkt_valid_o);
  a_r7_no_spurious_replay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(pkt_valid_o && !pkt_ready_i) && !replay_o) |=> !replay_o);
endmodule

// File: tb/sim_split_pkt_issuer.sv
`timescale 1ns/1ps
module sim_split_pkt_issuer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] num_pkts_i = '0;
  logic       pkt_ready_i = 1'b0;
  logic       bank_conflict_i = 1'b0;
  logic       resp_i = 1'b0;
  logic       pkt_valid_o;
  logic [1:0] pkt_idx_o;
  logic       replay_o, all_sent_o;
  logic [2:0] outs_cnt_o, recv_cnt_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  // bench model: 0 idle, 1 issue, 2 replay
  int m_st = 0, m_tot = 0, m_outs = 0, m_recv = 0;

  always #10 clk = ~clk;

  split_pkt_issuer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .num_pkts_i(num_pkts_i),
    .pkt_ready_i(pkt_ready_i), .bank_conflict_i(bank_conflict_i), .resp_i(resp_i),
    .pkt_valid_o(pkt_valid_o), .pkt_idx_o(pkt_idx_o), .replay_o(replay_o),
    .all_sent_o(all_sent_o), .outs_cnt_o(outs_cnt_o), .recv_cnt_o(recv_cnt_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int clampn(input int n);
    if (n == 0) return 1;
    if (n > 4) return 4;
    return n;
  endfunction

  task automatic step(input bit st, input int num, input bit rdy, input bit cf, input bit rs);
    int  sum;
    bit  v;
    @(negedge clk);
    start_i = st; num_pkts_i = 3'(num); pkt_ready_i = rdy;
    bank_conflict_i = cf; resp_i = rs;
    #2;
    sum = m_outs + m_recv;
    v = (m_st == 1) && (sum < m_tot);
    chk("R3 valid", int'(pkt_valid_o), int'(v));
    if (v) chk("R3 idx", int'(pkt_idx_o), sum);
    chk("R6 replay", int'(replay_o), int'(m_st == 2));
    chk("R10 all_sent", int'(all_sent_o), int'(m_st != 0 && m_outs == m_tot));
    chk("R4 outs", int'(outs_cnt_o), m_outs);
    chk("R8 recv", int'(recv_cnt_o), m_recv);
    @(posedge clk);
    if (st) begin
      m_tot = clampn(num); m_outs = 0; m_recv = 0; m_st = 1;
    end else begin
      bit acc, rok;
      acc = v && rdy;
      rok = rs && (m_outs != 0);
      m_outs = m_outs + int'(acc) - int'(rok);
      m_recv = m_recv + int'(rok);
      if (m_st == 2) m_st = 1;
      else if (v && !rdy && cf) m_st = 2;
    end
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 valid", int'(pkt_valid_o), 0);
    chk("R1 replay", int'(replay_o), 0);
    chk("R1 all_sent", int'(all_sent_o), 0);
    chk("R1 outs", int'(outs_cnt_o), 0);
    chk("R1 recv", int'(recv_cnt_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    step(0, 0, 1, 0, 1);
    chk("R1 idle after reset", int'(pkt_valid_o), 0);

    // R2 clamp 0 -> 1
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R2 clamp0 all_sent", int'(all_sent_o), 1);
    chk("R2 clamp0 outs", int'(outs_cnt_o), 1);
    // R2 clamp 7 -> 4
    step(1, 7, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0);
    chk("R2 clamp7 outs", int'(outs_cnt_o), 4);
    chk("R2 clamp7 all_sent", int'(all_sent_o), 1);

    // R5 plain refusal holds the index
    step(1, 3, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R5 valid", int'(pkt_valid_o), 1);
    chk("R5 idx", int'(pkt_idx_o), 0);
    chk("R5 outs", int'(outs_cnt_o), 0);
    step(0, 0, 1, 0, 0);
    chk("R4 idx advance", int'(pkt_idx_o), 1);
    // R6 conflict refusal
    step(0, 0, 0, 1, 0);
    chk("R6 replay set", int'(replay_o), 1);
    chk("R6 valid low", int'(pkt_valid_o), 0);
    step(0, 0, 1, 0, 0);
    chk("R6 replay clear", int'(replay_o), 0);
    chk("R6 resume idx", int'(pkt_idx_o), 1);
    // R7 conflict on accept ignored
    step(0, 0, 1, 1, 0);
    chk("R7 no replay", int'(replay_o), 0);
    chk("R7 outs", int'(outs_cnt_o), 2);

    // R9 response with nothing outstanding
    step(1, 2, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    chk("R9 recv", int'(recv_cnt_o), 0);
    chk("R9 outs", int'(outs_cnt_o), 0);
    // R8 combined accept and response
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 1);
    chk("R8 outs", int'(outs_cnt_o), 1);
    chk("R8 recv", int'(recv_cnt_o), 1);
    step(0, 0, 0, 0, 1);
    chk("R8 recv2", int'(recv_cnt_o), 2);
    chk("R3 done no valid", int'(pkt_valid_o), 0);

    // R2 restart mid-request with concurrent ready
    step(1, 4, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    step(1, 2, 1, 0, 1);
    chk("R2 restart outs", int'(outs_cnt_o), 0);
    chk("R2 restart recv", int'(recv_cnt_o), 0);
    chk("R2 restart idx", int'(pkt_idx_o), 0);

    // sweep all counts with pseudo-random handshakes
    for (int n = 0; n <= 7; n++) begin
      step(1, n, 0, 0, 0);
      for (int c = 0; c < 60; c++) begin
        int r;
        r = $urandom;
        step(0, 0, r[0] | r[1], r[2] & r[3], r[4] & r[5]);
      end
    end

    finish_run();
  end
endmodule